// File: doc/BRIEF.md
# SMI Feature Negotiation and Trigger

This block runs a one-shot handshake in which firmware asks for a set of system-management interrupt features and the hardware either locks that set in or refuses it. The host's supported features are a fixed 64-bit mask. Firmware writes a 64-bit request one byte at a time, least significant byte first in address order. It then writes the accept register. The request is checked against the host mask and against the rules that tie the broadcast bit to the hot-plug bits. If it passes, it is copied into a read-only negotiated register and the accept flag is set. After that the negotiated set cannot change until reset.

The block also watches writes to the APM control port. A command byte other than the two ACPI mode-switch codes raises an SMI, provided the APM enable bit of the SMI enable register is set. The SMI goes out as a one-cycle pulse, either to all CPUs or only to the requesting CPU, depending on whether broadcast was negotiated. A power-management control register carries a sticky lock bit that freezes itself and the global-enable bit of the SMI enable register.

Top module: `smi_negotiator`

## Requirements
- R1: After reset, the request, accept flag, negotiated set, SMI enable register and power-management control register all read 0, and neither SMI output is high.
- R2: Offsets 0x00-0x07 return the host feature mask (default 0x7), with byte i at offset i holding bits 8i+7..8i. Writes to these offsets change nothing.
- R3: Offsets 0x08-0x0F hold the request. A write to offset 0x08+i loads bits 8i+7..8i, and the value reads back the same way.
- R4: A write of any value to offset 0x10, while the accept flag is 0 and the request is valid, sets the accept flag (bit 0 of offset 0x10) to 1 and copies the request into the negotiated set at offsets 0x18-0x1F, which use the same byte order.
- R5: A request holding any bit that the host mask lacks is refused. The accept flag stays 0 and the negotiated set stays 0.
- R6: A request with hot-plug (bit 1) or hot-unplug (bit 2) set but broadcast (bit 0) clear is refused.
- R7: A request with hot-unplug (bit 2) set but hot-plug (bit 1) clear is refused.
- R8: Once the accept flag is 1, further writes to offset 0x10 change neither the flag nor the negotiated set, even after the request is rewritten.
- R9: An APM write of 0xE1 or 0x1E never raises either SMI output.
- R10: Any other APM write raises exactly one output, high for exactly the one cycle after the write, and only if bit 5 of the SMI enable register (offset 0x11) is set. The output is smi_all when negotiated bit 0 is 1, and smi_self otherwise.
- R11: Setting bit 4 of the power-management control register (offset 0x12) locks it. From then until reset, that bit and bit 0 of offset 0x11 ignore writes, while bit 5 of offset 0x11 stays writable.
- R12: cfg_err is 1 after reset exactly when the host mask offers hot-unplug (bit 2) without hot-plug (bit 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte at reg_addr (combinational) |
| apm_wr | input | 1 | APM control port write strobe |
| apm_data | input | 8 | APM command byte |
| smi_self | output | 1 | One-cycle SMI pulse to the requesting CPU |
| smi_all | output | 1 | One-cycle SMI pulse to all CPUs |
| cfg_err | output | 1 | Host mask is inconsistent |

## Verification
The main instance uses the default host mask 0x7, which offers all three dependent features. Every accept and refuse path of the checker is then reachable: a bit outside the mask (bit 3 or bit 63), each dependency violation, and the empty set. A second instance is built with host mask 0x5, which offers hot-unplug without hot-plug, so that the configuration-error output can be seen high. The default ACPI command codes 0xE1 and 0x1E are used so that both filtered values can be exercised next to an ordinary command byte.

// File: rtl/smi_neg_pkg.sv
package smi_neg_pkg;
  localparam int FEAT_W     = 64;
  localparam int BYTE_W     = 8;
  localparam int FEAT_BYTES = FEAT_W / BYTE_W;
  localparam int BSEL_W     = $clog2(FEAT_BYTES);
  localparam int REG_ADDR_W = 5;

  localparam logic [REG_ADDR_W-1:0] OFS_HOST  = 5'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_REQ   = 5'h08;
  localparam logic [REG_ADDR_W-1:0] OFS_OK    = 5'h10;
  localparam logic [REG_ADDR_W-1:0] OFS_SMIEN = 5'h11;
  localparam logic [REG_ADDR_W-1:0] OFS_PMCON = 5'h12;
  localparam logic [REG_ADDR_W-1:0] OFS_NEG   = 5'h18;

  localparam int BIT_BCAST  = 0;
  localparam int BIT_HP     = 1;
  localparam int BIT_HUP    = 2;
  localparam int SMIEN_GBL  = 0;
  localparam int SMIEN_APMC = 5;
  localparam int PMCON_LOCK = 4;

  function automatic logic feat_acceptable(input logic [FEAT_W-1:0] req,
                                           input logic [FEAT_W-1:0] host);
    logic hot_any;
    if (|(req & ~host)) return 1'b0;
    hot_any = req[BIT_HP] | req[BIT_HUP];
    if (hot_any && !req[BIT_BCAST]) return 1'b0;
    if (req[BIT_HUP] && !req[BIT_HP]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic host_misconfigured(input logic [FEAT_W-1:0] host);
    return host[BIT_HUP] & ~host[BIT_HP];
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [FEAT_W-1:0] v,
                                                  input logic [BSEL_W-1:0] idx);
    return v[idx*BYTE_W +: BYTE_W];
  endfunction

  function automatic logic in_window(input logic [REG_ADDR_W-1:0] addr,
                                     input logic [REG_ADDR_W-1:0] base);
    return addr[REG_ADDR_W-1:BSEL_W] == base[REG_ADDR_W-1:BSEL_W];
  endfunction
endpackage

// File: rtl/smi_feat_regs.sv
module smi_feat_regs
  import smi_neg_pkg::*;
#(
  parameter logic [FEAT_W-1:0] HOST_FEATURES = 64'h7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0]     wr_data,
  output logic [FEAT_W-1:0]     req_q,
  output logic [FEAT_W-1:0]     neg_q,
  output logic                  ok_q
);
  logic              req_hit;
  logic              ok_hit;
  logic              accept_now;
  logic [BSEL_W-1:0] byte_idx;

  assign byte_idx   = wr_addr[BSEL_W-1:0];
  assign req_hit    = wr_en && in_window(wr_addr, OFS_REQ);
  assign ok_hit     = wr_en && (wr_addr == OFS_OK);
  assign accept_now = ok_hit && !ok_q && feat_acceptable(req_q, HOST_FEATURES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      neg_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      if (req_hit) req_q[byte_idx*BYTE_W +: BYTE_W] <= wr_data;
      if (accept_now) begin
        neg_q <= req_q;
        ok_q  <= 1'b1;
      end
    end
  end

  assert_ok_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |=> ok_q && $stable(neg_q));
  assert_accept_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> feat_acceptable(neg_q, HOST_FEATURES));
  assert_neg_zero_until_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_q |-> neg_q == '0);
endmodule

// File: rtl/smi_pm_ctrl.sv
module smi_pm_ctrl
  import smi_neg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0]     wr_data,
  output logic [BYTE_W-1:0]     smi_en_q,
  output logic [BYTE_W-1:0]     pmcon_q
);
  logic locked;
  logic en_hit;
  logic pm_hit;

  assign locked = pmcon_q[PMCON_LOCK];
  assign en_hit = wr_en && (wr_addr == OFS_SMIEN);
  assign pm_hit = wr_en && (wr_addr == OFS_PMCON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_en_q <= '0;
      pmcon_q  <= '0;
    end else begin
      if (en_hit) begin
        smi_en_q <= wr_data;
        if (locked) smi_en_q[SMIEN_GBL] <= smi_en_q[SMIEN_GBL];
      end
      if (pm_hit) begin
        pmcon_q <= wr_data;
        if (locked) pmcon_q[PMCON_LOCK] <= 1'b1;
      end
    end
  end

  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  assert_gbl_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(smi_en_q[SMIEN_GBL]));
endmodule

// File: rtl/smi_apm_trigger.sv
module smi_apm_trigger
  import smi_neg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ACPI_ON_CMD  = 8'hE1,
  parameter logic [BYTE_W-1:0] ACPI_OFF_CMD = 8'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apm_wr,
  input  logic [BYTE_W-1:0] apm_data,
  input  logic              apmc_en,
  input  logic              bcast,
  output logic              smi_self,
  output logic              smi_all
);
  logic is_acpi_cmd;
  logic fire;

  assign is_acpi_cmd = (apm_data == ACPI_ON_CMD) || (apm_data == ACPI_OFF_CMD);
  assign fire        = apm_wr && !is_acpi_cmd && apmc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_self <= 1'b0;
      smi_all  <= 1'b0;
    end else begin
      smi_self <= fire && !bcast;
      smi_all  <= fire && bcast;
    end
  end

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smi_self, smi_all}));
  assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_self || smi_all) |-> $past(apm_wr) && $past(apmc_en));
  assert_acpi_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    apm_wr && is_acpi_cmd |=> !smi_self && !smi_all);
endmodule

// File: rtl/smi_negotiator.sv
module smi_negotiator
  import smi_neg_pkg::*;
#(
  parameter logic [FEAT_W-1:0] HOST_FEATURES = 64'h7,
  parameter logic [BYTE_W-1:0] ACPI_ON_CMD   = 8'hE1,
  parameter logic [BYTE_W-1:0] ACPI_OFF_CMD  = 8'h1E
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0]     reg_wdata,
  output logic [BYTE_W-1:0]     reg_rdata,
  input  logic                  apm_wr,
  input  logic [BYTE_W-1:0]     apm_data,
  output logic                  smi_self,
  output logic                  smi_all,
  output logic                  cfg_err
);
  logic [FEAT_W-1:0] req_q;
  logic [FEAT_W-1:0] neg_q;
  logic              ok_q;
  logic [BYTE_W-1:0] smi_en_q;
  logic [BYTE_W-1:0] pmcon_q;
  logic [BSEL_W-1:0] rd_idx;

  smi_feat_regs #(.HOST_FEATURES(HOST_FEATURES)) u_feat (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .req_q(req_q), .neg_q(neg_q), .ok_q(ok_q)
  );

  smi_pm_ctrl u_pm (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .smi_en_q(smi_en_q), .pmcon_q(pmcon_q)
  );

  smi_apm_trigger #(.ACPI_ON_CMD(ACPI_ON_CMD), .ACPI_OFF_CMD(ACPI_OFF_CMD)) u_apm (
    .clk(clk), .rst_n(rst_n), .apm_wr(apm_wr), .apm_data(apm_data),
    .apmc_en(smi_en_q[SMIEN_APMC]), .bcast(neg_q[BIT_BCAST]),
    .smi_self(smi_self), .smi_all(smi_all)
  );

  assign rd_idx = reg_addr[BSEL_W-1:0];

  always_comb begin
    reg_rdata = '0;
    if (in_window(reg_addr, OFS_HOST))     reg_rdata = pick_byte(HOST_FEATURES, rd_idx);
    else if (in_window(reg_addr, OFS_REQ)) reg_rdata = pick_byte(req_q, rd_idx);
    else if (in_window(reg_addr, OFS_NEG)) reg_rdata = pick_byte(neg_q, rd_idx);
    else if (reg_addr == OFS_OK)           reg_rdata = {{(BYTE_W-1){1'b0}}, ok_q};
    else if (reg_addr == OFS_SMIEN)        reg_rdata = smi_en_q;
    else if (reg_addr == OFS_PMCON)        reg_rdata = pmcon_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_err <= host_misconfigured(HOST_FEATURES);
  end

  assert_cfg_err_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 $stable(cfg_err));
endmodule

// File: tb/smi_negotiator_tb.sv
`timescale 1ns/1ps
module smi_negotiator_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       apm_wr = 1'b0;
  logic [7:0] apm_data = '0;
  logic       smi_self, smi_all, cfg_err;
  logic [7:0] bad_rdata;
  logic       bad_self, bad_all, bad_err;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  smi_negotiator u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .apm_wr(apm_wr),
    .apm_data(apm_data), .smi_self(smi_self), .smi_all(smi_all), .cfg_err(cfg_err)
  );

  smi_negotiator #(.HOST_FEATURES(64'h5)) u_bad (
    .clk(clk), .rst_n(rst_n), .reg_wr(1'b0), .reg_addr(5'h0),
    .reg_wdata(8'h0), .reg_rdata(bad_rdata), .apm_wr(1'b0),
    .apm_data(8'h0), .smi_self(bad_self), .smi_all(bad_all), .cfg_err(bad_err)
  );

  // bit 64 = expected accept, bits 63:0 = request
  localparam logic [64:0] VEC [9] = '{
    {1'b1, 64'h0},                  // R4 empty set
    {1'b1, 64'h1},                  // R4 broadcast only
    {1'b1, 64'h3},                  // R4 broadcast + hot-plug
    {1'b1, 64'h7},                  // R4 all three
    {1'b0, 64'h2},                  // R6 hot-plug without broadcast
    {1'b0, 64'h4},                  // R6 hot-unplug without broadcast
    {1'b0, 64'h5},                  // R7 hot-unplug without hot-plug
    {1'b0, 64'h8},                  // R5 outside host mask
    {1'b0, 64'h8000_0000_0000_0001} // R5 top byte outside mask
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd64(input logic [4:0] base, output logic [63:0] v);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      rd(base + 5'(i), b);
      v[i*8 +: 8] = b;
    end
  endtask

  task automatic wr64(input logic [4:0] base, input logic [63:0] v);
    for (int i = 0; i < 8; i++) wr(base + 5'(i), v[i*8 +: 8]);
  endtask

  // drives one APM write; returns {self,all} in the pulse cycle and the cycle after
  task automatic apm(input logic [7:0] cmd, output logic [1:0] p1, output logic [1:0] p2);
    @(negedge clk);
    apm_wr = 1'b1; apm_data = cmd;
    @(negedge clk);
    apm_wr = 1'b0;
    p1 = {smi_self, smi_all};
    @(negedge clk);
    p2 = {smi_self, smi_all};
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [7:0]  b;
    logic [1:0]  p1, p2;
    do_reset();

    // R1 reset state
    rd64(5'h08, v); check("R1 request", v, 64'h0);
    rd64(5'h18, v); check("R1 negotiated", v, 64'h0);
    rd(5'h10, b); check("R1 accept", {56'h0, b}, 64'h0);
    rd(5'h11, b); check("R1 smi enable", {56'h0, b}, 64'h0);
    rd(5'h12, b); check("R1 pm control", {56'h0, b}, 64'h0);
    check("R1 pulses", {62'h0, smi_self, smi_all}, 64'h0);

    // R12 config error
    check("R12 good host", {63'h0, cfg_err}, 64'h0);
    check("R12 bad host", {63'h0, bad_err}, 64'h1);

    // R2 host mask read-only
    wr(5'h00, 8'hFF); wr(5'h07, 8'hAA);
    rd64(5'h00, v); check("R2 host mask", v, 64'h7);

    // R3 little-endian request bytes
    wr64(5'h08, 64'h0123_4567_89AB_CDEF);
    rd64(5'h08, v); check("R3 request bytes", v, 64'h0123_4567_89AB_CDEF);
    rd(5'h0F, b); check("R3 top byte", {56'h0, b}, 64'h01);

    // negotiation table
    for (int k = 0; k < 9; k++) begin
      logic [63:0] req;
      logic        exp_ok;
      req = VEC[k][63:0];
      exp_ok = VEC[k][64];
      do_reset();
      wr64(5'h08, req);
      wr(5'h10, 8'h5A);
      rd(5'h10, b);
      check($sformatf("R4/R5/R6/R7 accept vec%0d", k), {56'h0, b}, {63'h0, exp_ok});
      rd64(5'h18, v);
      check($sformatf("R4/R5/R6/R7 negotiated vec%0d", k), v, exp_ok ? req : 64'h0);
    end

    // R8 locked after acceptance
    do_reset();
    wr64(5'h08, 64'h1);
    wr(5'h10, 8'h1);
    wr64(5'h08, 64'h7);
    wr(5'h10, 8'h1);
    rd64(5'h18, v); check("R8 negotiated locked", v, 64'h1);
    rd(5'h10, b); check("R8 accept held", {56'h0, b}, 64'h1);

    // R10 broadcast negotiated (bit0=1): APM enable off then on
    p1 = '0; p2 = '0;
    apm(8'h42, p1, p2); check("R10 disabled no pulse", {62'h0, p1}, 64'h0);
    wr(5'h11, 8'h20);
    apm(8'h42, p1, p2);
    check("R10 broadcast pulse", {62'h0, p1}, 64'h1);
    check("R10 pulse one cycle", {62'h0, p2}, 64'h0);
    // R9 ACPI commands
    apm(8'hE1, p1, p2); check("R9 enable cmd silent", {60'h0, p1, p2}, 64'h0);
    apm(8'h1E, p1, p2); check("R9 disable cmd silent", {60'h0, p1, p2}, 64'h0);

    // R10 no broadcast negotiated: current CPU only
    do_reset();
    wr(5'h10, 8'h1);
    wr(5'h11, 8'h20);
    apm(8'h00, p1, p2);
    check("R10 self pulse", {62'h0, p1}, 64'h2);
    check("R10 self one cycle", {62'h0, p2}, 64'h0);

    // R11 lock
    do_reset();
    wr(5'h11, 8'h01);
    wr(5'h12, 8'h10);
    wr(5'h12, 8'h03);
    rd(5'h12, b); check("R11 lock sticky", {56'h0, b}, 64'h13);
    wr(5'h11, 8'h20);
    rd(5'h11, b); check("R11 global bit frozen", {56'h0, b}, 64'h21);
    do_reset();
    wr(5'h12, 8'h10);
    wr(5'h11, 8'h01);
    rd(5'h11, b); check("R11 frozen at zero", {56'h0, b}, 64'h00);
    do_reset();
    rd(5'h12, b); check("R11 reset clears lock", {56'h0, b}, 64'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule